// File: doc/BRIEF.md
# Fully Associative Byte Cache with Selectable Write Policy

This block is a very small data cache placed between a processor port that issues single-byte loads and stores and a slower memory port that moves whole blocks. Any line may hold any block. The tag match runs in parallel across all lines, and a least-recently-used order picks the line to replace. The block counts the processor accesses that hit and the accesses that miss.

A build-time parameter selects the store policy. The write-back build keeps a dirty flag for each line. It copies a line to memory only when that line is evicted while dirty, or when a flush is requested. The write-through build keeps no dirty state and sends every store byte to memory. Both builds allocate a line on a store miss.

With the default parameters the cache has two lines, each holding a two-byte block, behind a four-bit byte address. The processor holds its request until the cache answers with a one-cycle ready pulse. The cache holds its memory request until memory answers with a one-cycle done pulse.

Top module: `fa_cache`

## Requirements
- R1: The byte address splits into a 3-bit tag (`cpu_addr[3:1]`) and a 1-bit offset (`cpu_addr[0]`), and there is no index field. In a block transfer the byte at offset 0 travels on bits [7:0] and the byte at offset 1 on bits [15:8], and the block address always has its offset bit at 0.
- R2: Any miss, whether load or store, reads the whole block from memory (`mem_req=1`, `mem_we=0`, `mem_blk=1`) before the access completes. A load miss returns the byte from the fetched block.
- R3: A store miss first allocates the line and then updates the cached byte, so a later load of that address returns the stored value.
- R4: A missing block goes into an invalid line when one exists. Otherwise it replaces the least recently used line. Both hits and fills make the accessed line the most recent.
- R5: In the write-through build, every store (hit or miss) performs one byte write (`mem_we=1`, `mem_blk=0`, byte on `mem_wdata[7:0]`, full byte address). Evictions and flushes never write to memory.
- R6: In the write-back build, memory writes are always whole blocks. A store sets the line dirty. Evicting a clean line writes nothing. Evicting a dirty line writes its block to memory before the new block is fetched.
- R7: `hit_count` and `miss_count` reset to zero. Exactly one of them increments by one per completed access, and the new value is visible in the same cycle as `cpu_ready`.
- R8: `cpu_ready` is a one-cycle pulse, and `cpu_rdata` is valid during it for loads. A load hit, or a write-back store hit, raises `cpu_ready` in the cycle after the request is first presented. `cpu_ready` and `mem_req` are never high together.
- R9: A flush held on `flush_req` while the cache is idle writes every valid dirty line back as a whole block, exactly once each. The lines stay valid and become clean. The cache then pulses `flush_done` for one cycle. In the write-through build a flush produces no memory traffic.
- R10: The access run load 1, load 7, store 0, store 5, load 10, store 5, store 10, store 5, store 10, started from an empty cache, gives 4 misses and 5 hits in either build.
- R11: Once raised, `mem_req` stays high with stable address, direction and size until the cycle in which `mem_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = byte store, 0 = byte load |
| cpu_addr | input | 4 | Byte address |
| cpu_wdata | input | 8 | Store byte |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 8 | Load byte, valid with `cpu_ready` |
| flush_req | input | 1 | Flush request, held until `flush_done` |
| flush_done | output | 1 | One-cycle flush completion pulse |
| mem_req | output | 1 | Memory request, held until `mem_done` |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_blk | output | 1 | 1 = whole block, 0 = single byte |
| mem_addr | output | 4 | Byte address, block-aligned for block transfers |
| mem_wdata | output | 16 | Write block, or the write byte on bits [7:0] |
| mem_rdata | input | 16 | Read block, valid with `mem_done` |
| mem_done | input | 1 | One-cycle memory completion pulse |
| hit_count | output | 16 | Completed accesses that hit |
| miss_count | output | 16 | Completed accesses that missed |

## Verification
The bound checker covers the handshake properties on every cycle. It checks that the ready and flush-done pulses last one cycle, that a memory request stays stable until done, that block addresses are aligned, that each build uses the right transfer size for writes, and that the counters move only with ready and by exactly one. Other behaviour can only be shown by the bench scenarios run against its behavioural model: which line is replaced, that a dirty victim is written before the fill, that clean victims produce no traffic, the returned load bytes, and the memory image after evictions and flushes. These scenarios include the nine-access reference run, a least-recently-used ordering pattern, a store-miss read-back, flushes, and a long pseudo-random run on both builds.

// File: rtl/fa_cache_pkg.sv
package fa_cache_pkg;

    // Controller phases shared by the cache top and its checker.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVICT,
        ST_FILL,
        ST_WTHRU,
        ST_DONE,
        ST_FSCAN,
        ST_FWRITE,
        ST_FDONE
    } cache_state_e;

endpackage

// File: rtl/fa_cache_match.sv
module fa_cache_match #(
    parameter int LINES = 2,
    parameter int TAG_W = 3,
    parameter int IDX_W = 1
) (
    input  logic [LINES-1:0]            valid,
    input  logic [LINES-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]            key,
    output logic                        hit,
    output logic [IDX_W-1:0]            idx
);

    logic [LINES-1:0] eq;

    for (genvar i = 0; i < LINES; i++) begin : g_cmp
        assign eq[i] = valid[i] && (tags[i] == key);
    end

    always_comb begin
        hit = |eq;
        idx = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (eq[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/fa_cache_victim.sv
module fa_cache_victim #(
    parameter int LINES = 2,
    parameter int IDX_W = 1
) (
    input  logic [LINES-1:0]            valid,
    input  logic [LINES-1:0][IDX_W-1:0] rank,
    output logic [IDX_W-1:0]            idx
);

    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(LINES - 1);

    logic [LINES-1:0] is_old;

    for (genvar i = 0; i < LINES; i++) begin : g_age
        assign is_old[i] = (rank[i] == OLDEST);
    end

    // Lowest invalid line first; otherwise the line ranked oldest.
    always_comb begin
        logic found;
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < LINES; i++) begin
            if (!found && !valid[i]) begin
                idx   = IDX_W'(i);
                found = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < LINES; i++) begin
                if (is_old[i]) idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/fa_cache_counters.sv
module fa_cache_counters #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_hit,
    input  logic             inc_miss,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] miss_count
);

    typedef struct packed {
        logic [CNT_W-1:0] hits;
        logic [CNT_W-1:0] misses;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc_hit)  cnt_d.hits   = cnt_q.hits + 1'b1;
        if (inc_miss) cnt_d.misses = cnt_q.misses + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hit_count  = cnt_q.hits;
    assign miss_count = cnt_q.misses;

endmodule

// File: rtl/fa_cache.sv
module fa_cache
    import fa_cache_pkg::*;
#(
    parameter int LINES      = 2,
    parameter int TAG_W      = 3,
    parameter int OFF_W      = 1,
    parameter int DATA_W     = 8,
    parameter int CNT_W      = 16,
    parameter bit WRITE_BACK = 1'b1,
    localparam int ADDR_W    = TAG_W + OFF_W,
    localparam int BLK_W     = (1 << OFF_W) * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              flush_req,
    output logic              flush_done,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_blk,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BLK_W-1:0]  mem_wdata,
    input  logic [BLK_W-1:0]  mem_rdata,
    input  logic              mem_done,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);

    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(LINES - 1);

    typedef logic [LINES-1:0][IDX_W-1:0] rank_t;

    typedef struct packed {
        cache_state_e               st;
        logic [LINES-1:0]           valid;
        logic [LINES-1:0]           dirty;
        logic [LINES-1:0][TAG_W-1:0] tag;
        logic [LINES-1:0][BLK_W-1:0] data;
        rank_t                      rank;
        logic [IDX_W-1:0]           cur;
        logic                       was_hit;
        logic [DATA_W-1:0]          rdata;
    } state_t;

    state_t d, q;

    function automatic state_t reset_state();
        state_t s;
        s    = '0;
        s.st = ST_IDLE;
        for (int i = 0; i < LINES; i++) s.rank[i] = IDX_W'(i);
        return s;
    endfunction

    // Make line k the most recent; lines that were newer age by one.
    function automatic rank_t touch(input rank_t r, input logic [IDX_W-1:0] k);
        rank_t t;
        t = r;
        for (int j = 0; j < LINES; j++) begin
            if (r[j] < r[k]) t[j] = IDX_W'(r[j] + 1'b1);
        end
        t[k] = '0;
        return t;
    endfunction

    function automatic logic [BLK_W-1:0] put_byte(input logic [BLK_W-1:0] blk,
                                                  input logic [OFF_W-1:0] off,
                                                  input logic [DATA_W-1:0] b);
        logic [BLK_W-1:0] r;
        r = blk;
        r[off*DATA_W +: DATA_W] = b;
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] get_byte(input logic [BLK_W-1:0] blk,
                                                   input logic [OFF_W-1:0] off);
        return blk[off*DATA_W +: DATA_W];
    endfunction

    logic [TAG_W-1:0] req_tag;
    logic [OFF_W-1:0] req_off;
    logic             lk_hit;
    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] vic_idx;
    logic             enter_done;
    logic             inc_hit;
    logic             inc_miss;

    assign req_tag = cpu_addr[ADDR_W-1:OFF_W];
    assign req_off = cpu_addr[OFF_W-1:0];

    fa_cache_match #(.LINES(LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_match (
        .valid (q.valid),
        .tags  (q.tag),
        .key   (req_tag),
        .hit   (lk_hit),
        .idx   (lk_idx)
    );

    fa_cache_victim #(.LINES(LINES), .IDX_W(IDX_W)) u_victim (
        .valid (q.valid),
        .rank  (q.rank),
        .idx   (vic_idx)
    );

    fa_cache_counters #(.CNT_W(CNT_W)) u_counters (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc_hit    (inc_hit),
        .inc_miss   (inc_miss),
        .hit_count  (hit_count),
        .miss_count (miss_count)
    );

    always_comb begin
        d          = q;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_blk    = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        flush_done = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (lk_hit) begin
                        d.cur     = lk_idx;
                        d.was_hit = 1'b1;
                        d.rank    = touch(q.rank, lk_idx);
                        if (cpu_we) begin
                            d.data[lk_idx] = put_byte(q.data[lk_idx], req_off, cpu_wdata);
                            if (WRITE_BACK) begin
                                d.dirty[lk_idx] = 1'b1;
                                d.st            = ST_DONE;
                            end else begin
                                d.st = ST_WTHRU;
                            end
                        end else begin
                            d.rdata = get_byte(q.data[lk_idx], req_off);
                            d.st    = ST_DONE;
                        end
                    end else begin
                        d.cur     = vic_idx;
                        d.was_hit = 1'b0;
                        if (WRITE_BACK && q.valid[vic_idx] && q.dirty[vic_idx]) begin
                            d.st = ST_EVICT;
                        end else begin
                            d.valid[vic_idx] = 1'b0;
                            d.st             = ST_FILL;
                        end
                    end
                end else if (flush_req) begin
                    d.cur = '0;
                    d.st  = ST_FSCAN;
                end
            end
            ST_EVICT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_blk   = 1'b1;
                mem_addr  = {q.tag[q.cur], {OFF_W{1'b0}}};
                mem_wdata = q.data[q.cur];
                if (mem_done) begin
                    d.valid[q.cur] = 1'b0;
                    d.dirty[q.cur] = 1'b0;
                    d.st           = ST_FILL;
                end
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_blk  = 1'b1;
                mem_addr = {req_tag, {OFF_W{1'b0}}};
                if (mem_done) begin
                    d.valid[q.cur] = 1'b1;
                    d.dirty[q.cur] = 1'b0;
                    d.tag[q.cur]   = req_tag;
                    d.data[q.cur]  = mem_rdata;
                    d.rank         = touch(q.rank, q.cur);
                    d.rdata        = get_byte(mem_rdata, req_off);
                    if (cpu_we) begin
                        d.data[q.cur]  = put_byte(mem_rdata, req_off, cpu_wdata);
                        d.dirty[q.cur] = WRITE_BACK;
                        d.st           = WRITE_BACK ? ST_DONE : ST_WTHRU;
                    end else begin
                        d.st = ST_DONE;
                    end
                end
            end
            ST_WTHRU: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cpu_addr;
                mem_wdata = BLK_W'(cpu_wdata);
                if (mem_done) d.st = ST_DONE;
            end
            ST_DONE: d.st = ST_IDLE;
            ST_FSCAN: begin
                if (q.valid[q.cur] && q.dirty[q.cur]) d.st = ST_FWRITE;
                else if (q.cur == LAST)                d.st = ST_FDONE;
                else                                   d.cur = q.cur + 1'b1;
            end
            ST_FWRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_blk   = 1'b1;
                mem_addr  = {q.tag[q.cur], {OFF_W{1'b0}}};
                mem_wdata = q.data[q.cur];
                if (mem_done) begin
                    d.dirty[q.cur] = 1'b0;
                    if (q.cur == LAST) begin
                        d.st = ST_FDONE;
                    end else begin
                        d.cur = q.cur + 1'b1;
                        d.st  = ST_FSCAN;
                    end
                end
            end
            ST_FDONE: begin
                flush_done = 1'b1;
                d.st       = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= reset_state();
        else        q <= d;
    end

    assign enter_done = (d.st == ST_DONE) && (q.st != ST_DONE);
    assign inc_hit    = enter_done && d.was_hit;
    assign inc_miss   = enter_done && !d.was_hit;
    assign cpu_ready  = (q.st == ST_DONE);
    assign cpu_rdata  = q.rdata;

endmodule

// File: rtl/fa_cache_chk.sv
module fa_cache_chk #(
    parameter int TAG_W      = 3,
    parameter int OFF_W      = 1,
    parameter int DATA_W     = 8,
    parameter int CNT_W      = 16,
    parameter bit WRITE_BACK = 1'b1,
    localparam int ADDR_W    = TAG_W + OFF_W,
    localparam int BLK_W     = (1 << OFF_W) * DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_ready,
    input logic              flush_done,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_blk,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_done,
    input logic [CNT_W-1:0]  hit_count,
    input logic [CNT_W-1:0]  miss_count
);

    // R8: completion is a single-cycle pulse
    a_r8_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R8: no memory traffic while an access is being reported complete
    a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !mem_req);

    // R7: counters move only in a completion cycle
    a_r7_counts_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ready |-> ($stable(hit_count) && $stable(miss_count)));

    // R7: each completion adds exactly one to the total
    a_r7_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> (CNT_W'(hit_count + miss_count) ==
                       CNT_W'($past(hit_count) + $past(miss_count) + 1'b1)));

    // R11: request held stable until memory answers
    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_done) |=> (mem_req && $stable(mem_addr) &&
                                    $stable(mem_we) && $stable(mem_blk)));

    // R1: block transfers are block aligned
    a_r1_block_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_blk) |-> (mem_addr[OFF_W-1:0] == '0));

    // R9: flush completion is a single-cycle pulse
    a_r9_flush_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |=> !flush_done);

    if (WRITE_BACK) begin : g_wb
        // R6: write-back build writes memory only in whole blocks
        a_r6_block_writes: assert property (@(posedge clk) disable iff (!rst_n)
            (mem_req && mem_we) |-> mem_blk);
    end else begin : g_wt
        // R5: write-through build writes memory only as single bytes
        a_r5_byte_writes: assert property (@(posedge clk) disable iff (!rst_n)
            (mem_req && mem_we) |-> !mem_blk);
    end

endmodule

bind fa_cache fa_cache_chk #(
    .TAG_W      (TAG_W),
    .OFF_W      (OFF_W),
    .DATA_W     (DATA_W),
    .CNT_W      (CNT_W),
    .WRITE_BACK (WRITE_BACK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_ready  (cpu_ready),
    .flush_done (flush_done),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_blk    (mem_blk),
    .mem_addr   (mem_addr),
    .mem_done   (mem_done),
    .hit_count  (hit_count),
    .miss_count (miss_count)
);

// File: tb/sim_fa_cache.sv
module sim_fa_cache;

    localparam int LINES = 2;
    localparam int NBYTE = 16;
    localparam int LAT   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        cpu_req [2];
    logic        cpu_we [2];
    logic [3:0]  cpu_addr [2];
    logic [7:0]  cpu_wdata [2];
    logic        cpu_ready [2];
    logic [7:0]  cpu_rdata [2];
    logic        flush_req [2];
    logic        flush_done [2];
    logic        mem_req [2];
    logic        mem_we [2];
    logic        mem_blk [2];
    logic [3:0]  mem_addr [2];
    logic [15:0] mem_wdata [2];
    logic [15:0] mem_rdata [2];
    logic        mem_done [2];
    logic [15:0] hit_cnt [2];
    logic [15:0] miss_cnt [2];

    fa_cache #(.WRITE_BACK(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req[0]), .cpu_we(cpu_we[0]),
        .cpu_addr(cpu_addr[0]), .cpu_wdata(cpu_wdata[0]), .cpu_ready(cpu_ready[0]),
        .cpu_rdata(cpu_rdata[0]), .flush_req(flush_req[0]), .flush_done(flush_done[0]),
        .mem_req(mem_req[0]), .mem_we(mem_we[0]), .mem_blk(mem_blk[0]),
        .mem_addr(mem_addr[0]), .mem_wdata(mem_wdata[0]), .mem_rdata(mem_rdata[0]),
        .mem_done(mem_done[0]), .hit_count(hit_cnt[0]), .miss_count(miss_cnt[0]));

    fa_cache #(.WRITE_BACK(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req[1]), .cpu_we(cpu_we[1]),
        .cpu_addr(cpu_addr[1]), .cpu_wdata(cpu_wdata[1]), .cpu_ready(cpu_ready[1]),
        .cpu_rdata(cpu_rdata[1]), .flush_req(flush_req[1]), .flush_done(flush_done[1]),
        .mem_req(mem_req[1]), .mem_we(mem_we[1]), .mem_blk(mem_blk[1]),
        .mem_addr(mem_addr[1]), .mem_wdata(mem_wdata[1]), .mem_rdata(mem_rdata[1]),
        .mem_done(mem_done[1]), .hit_count(hit_cnt[1]), .miss_count(miss_cnt[1]));

    int n_checks = 0;
    int n_fails  = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] init_byte(input int b);
        return 8'(b * 37 + 11);
    endfunction

    // ---------------- memory models, sampled on the falling edge ----------------
    logic [7:0] mem [2][NBYTE];
    int mcnt [2];
    int n_wblk [2];
    int n_rblk [2];
    int n_wbyte [2];
    int seq [2];
    int wblk_seq [2];
    int rblk_seq [2];
    logic [3:0] held_addr [2];

    always @(negedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (!rst_n) begin
                for (int b = 0; b < NBYTE; b++) mem[k][b] = init_byte(b);
                mem_done[k]  <= 1'b0;
                mem_rdata[k] <= '0;
                mcnt[k] = 0; n_wblk[k] = 0; n_rblk[k] = 0; n_wbyte[k] = 0;
                seq[k] = 0; wblk_seq[k] = 0; rblk_seq[k] = 0;
            end else if (mem_done[k]) begin
                mem_done[k] <= 1'b0;
            end else if (mem_req[k]) begin
                if (mcnt[k] == 0) held_addr[k] = mem_addr[k];
                else check(mem_addr[k] == held_addr[k], "R11 address held", mem_addr[k], held_addr[k]);
                if (mem_blk[k]) check(mem_addr[k][0] == 1'b0, "R1 block alignment", mem_addr[k][0], 0);
                if (mcnt[k] == LAT) begin
                    int a;
                    a = {mem_addr[k][3:1], 1'b0};
                    seq[k]++;
                    if (mem_we[k] && mem_blk[k]) begin
                        mem[k][a]     = mem_wdata[k][7:0];
                        mem[k][a + 1] = mem_wdata[k][15:8];
                        n_wblk[k]++;
                        wblk_seq[k] = seq[k];
                    end else if (mem_we[k]) begin
                        mem[k][mem_addr[k]] = mem_wdata[k][7:0];
                        n_wbyte[k]++;
                    end else begin
                        mem_rdata[k] <= {mem[k][a + 1], mem[k][a]};
                        n_rblk[k]++;
                        rblk_seq[k] = seq[k];
                    end
                    mem_done[k] <= 1'b1;
                    mcnt[k] = 0;
                end else begin
                    mcnt[k]++;
                end
            end
        end
    end

    // ---------------- behavioural reference model ----------------
    logic [7:0] view [NBYTE];   // architectural value of every byte
    logic [7:0] expm [NBYTE];   // expected memory image
    bit         bdirty [NBYTE/2];
    int         lru [$];        // block numbers, most recent first
    int         m_hits;
    int         m_misses;

    task automatic model_init();
        for (int b = 0; b < NBYTE; b++) begin
            view[b] = init_byte(b);
            expm[b] = init_byte(b);
        end
        for (int b = 0; b < NBYTE / 2; b++) bdirty[b] = 1'b0;
        lru.delete();
        m_hits = 0;
        m_misses = 0;
    endtask

    task automatic mem_compare(input int k, input string req);
        int bad;
        bad = 0;
        for (int b = 0; b < NBYTE; b++) if (mem[k][b] !== expm[b]) bad++;
        check(bad == 0, req, bad, 0);
    endtask

    task automatic access(input int k, input bit wb, input bit we, input logic [3:0] a,
                          input logic [7:0] wd, input string rtag);
        int blk, pos, lat, s_wb, s_rb, s_wy;
        bit hit;
        int e_wb, e_rb, e_wy;
        logic [7:0] e_rd;
        blk = int'(a) / 2;
        pos = -1;
        foreach (lru[i]) if (lru[i] == blk) pos = i;
        hit = (pos >= 0);
        e_wb = 0; e_rb = 0; e_wy = 0;
        if (hit) begin
            lru.delete(pos);
            lru.push_front(blk);
            m_hits++;
        end else begin
            if (lru.size() == LINES) begin
                int v;
                v = lru.pop_back();
                if (wb && bdirty[v]) begin
                    expm[2 * v]     = view[2 * v];
                    expm[2 * v + 1] = view[2 * v + 1];
                    bdirty[v] = 1'b0;
                    e_wb = 1;
                end
            end
            lru.push_front(blk);
            e_rb = 1;
            m_misses++;
        end
        if (we) begin
            view[a] = wd;
            if (wb) bdirty[blk] = 1'b1;
            else begin
                expm[a] = wd;
                e_wy = 1;
            end
        end
        e_rd = view[a];

        s_wb = n_wblk[k]; s_rb = n_rblk[k]; s_wy = n_wbyte[k];
        @(negedge clk);
        cpu_req[k] = 1'b1; cpu_we[k] = we; cpu_addr[k] = a; cpu_wdata[k] = wd;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!cpu_ready[k] && lat < 200);
        check(cpu_ready[k] === 1'b1, "R8 completion", lat, 0);
        if (!we) check(cpu_rdata[k] === e_rd, rtag, cpu_rdata[k], e_rd);
        check(int'(hit_cnt[k]) == m_hits, "R7 hit count", hit_cnt[k], m_hits);
        check(int'(miss_cnt[k]) == m_misses, "R7 miss count", miss_cnt[k], m_misses);
        if (hit && (wb || !we)) check(lat == 1, "R8 hit latency", lat, 1);
        check(n_rblk[k] - s_rb == e_rb, "R2 block fetch", n_rblk[k] - s_rb, e_rb);
        check(n_wblk[k] - s_wb == e_wb, wb ? "R6 victim write" : "R5 no eviction write",
              n_wblk[k] - s_wb, e_wb);
        check(n_wbyte[k] - s_wy == e_wy, "R5 byte write", n_wbyte[k] - s_wy, e_wy);
        if (e_wb == 1) check(wblk_seq[k] < rblk_seq[k], "R6 write before fill",
                             wblk_seq[k], rblk_seq[k]);
        mem_compare(k, wb ? "R6 memory image" : "R5 memory image");
        cpu_req[k] = 1'b0;
    endtask

    task automatic flush(input int k, input bit wb);
        int nd, s_wb, s_wy, w;
        nd = 0;
        for (int b = 0; b < NBYTE / 2; b++) begin
            if (wb && bdirty[b]) begin
                expm[2 * b] = view[2 * b];
                expm[2 * b + 1] = view[2 * b + 1];
                bdirty[b] = 1'b0;
                nd++;
            end
        end
        s_wb = n_wblk[k]; s_wy = n_wbyte[k];
        @(negedge clk);
        flush_req[k] = 1'b1;
        w = 0;
        do begin
            @(negedge clk);
            w++;
        end while (!flush_done[k] && w < 200);
        check(flush_done[k] === 1'b1, "R9 flush done", w, 0);
        flush_req[k] = 1'b0;
        check(n_wblk[k] - s_wb == nd, "R9 dirty lines written", n_wblk[k] - s_wb, nd);
        check(n_wbyte[k] - s_wy == 0, "R9 no byte writes", n_wbyte[k] - s_wy, 0);
        mem_compare(k, "R9 memory after flush");
        @(negedge clk);
        check(flush_done[k] === 1'b0, "R9 flush pulse width", flush_done[k], 0);
    endtask

    task automatic run(input int k, input bit wb);
        logic [3:0] ref_a [9];
        bit         ref_w [9];
        int         h0, m0;
        int unsigned lcg;
        ref_a = '{4'd1, 4'd7, 4'd0, 4'd5, 4'd10, 4'd5, 4'd10, 4'd5, 4'd10};
        ref_w = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
        model_init();
        // R10 reference run (includes invalid-first fill and dirty/clean victims)
        for (int i = 0; i < 9; i++) access(k, wb, ref_w[i], ref_a[i], 8'(8'hA0 + i), "R2 load data");
        check(int'(hit_cnt[k]) == 5, "R10 hits", hit_cnt[k], 5);
        check(int'(miss_cnt[k]) == 4, "R10 misses", miss_cnt[k], 4);
        flush(k, wb);
        // lines stay valid after a flush
        h0 = m_hits;
        access(k, wb, 1'b0, 4'd5, 8'h00, "R9 data kept after flush");
        access(k, wb, 1'b0, 4'd10, 8'h00, "R9 data kept after flush");
        check(m_hits - h0 == 2, "R9 lines valid after flush", m_hits - h0, 2);
        // R4 ordering: 12,14,12 then 0 must replace 14
        access(k, wb, 1'b0, 4'd12, 8'h00, "R4 load");
        access(k, wb, 1'b0, 4'd14, 8'h00, "R4 load");
        access(k, wb, 1'b0, 4'd13, 8'h00, "R1 upper lane");
        access(k, wb, 1'b0, 4'd0, 8'h00, "R4 load");
        m0 = int'(miss_cnt[k]);
        access(k, wb, 1'b0, 4'd12, 8'h00, "R4 recent line kept");
        check(int'(miss_cnt[k]) == m0, "R4 recent line kept", miss_cnt[k], m0);
        // R3 store miss then read back
        access(k, wb, 1'b1, 4'd9, 8'h5C, "R3 store");
        access(k, wb, 1'b0, 4'd9, 8'h00, "R3 store-miss readback");
        // pseudo-random traffic
        lcg = 32'h1234_5678 + k;
        for (int i = 0; i < 80; i++) begin
            lcg = lcg * 1103515245 + 12345;
            access(k, wb, lcg[20], lcg[19:16], lcg[27:20], "R2 load data");
        end
        flush(k, wb);
    endtask

    initial begin
        for (int k = 0; k < 2; k++) begin
            cpu_req[k] = 1'b0; cpu_we[k] = 1'b0; cpu_addr[k] = '0;
            cpu_wdata[k] = '0; flush_req[k] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            check(hit_cnt[k] == 16'd0, "R7 reset hit count", hit_cnt[k], 0);
            check(miss_cnt[k] == 16'd0, "R7 reset miss count", miss_cnt[k], 0);
            check(cpu_ready[k] === 1'b0, "R8 reset ready", cpu_ready[k], 0);
            check(mem_req[k] === 1'b0, "R11 reset request", mem_req[k], 0);
        end
        run(0, 1'b1);
        run(1, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule